// File: doc/BRIEF.md
# Sequence-numbered link retry buffer

This block is the transmit half of a reliable packet link. Every data packet handed to it leaves on the output stream tagged with a 12-bit sequence number, and a copy is kept in a small replay store until the far end confirms it. The far end's confirmations arrive as single-cycle events on a separate input. A positive acknowledge releases stored packets. A negative acknowledge releases the packets it vouches for and triggers a go-back-N replay of everything newer. If the store is non-empty and no confirmation is seen for a programmable number of cycles, the whole store is sent again.

A packet is one beat of `DATA_W` bits. New packets pass straight through to the output in the same cycle they are accepted. Replayed packets are marked with a flag so the framing logic downstream can tell them apart. While a replay is in progress, new packets are held off. New packets are also held off when the store is full.

Top module: `lrb_top`

## Requirements
- R1: After reset the first fresh packet carries sequence 0. Each later fresh packet carries the previous fresh number plus one, modulo 4096. Fresh beats show `out_retry`=0 and the payload unchanged on `out_data`, with the number on `out_seq`.
- R2: A packet is accepted (`in_valid` and `in_ready` high) in the same cycle it is presented on the output, and `out_ready` is high in that cycle. After reset, with the input idle, `out_valid` is 0 and `in_ready` follows `out_ready`.
- R3: No more than `DEPTH` (default 8) packets are ever outstanding. While `DEPTH` are outstanding, `in_ready` is 0.
- R4: An event with `ev_nak`=0 (acknowledge) and number N frees every outstanding packet up to and including N. It does this only when (N+1 − oldest outstanding) mod 4096 does not exceed the outstanding count; otherwise it has no effect.
- R5: An event with `ev_nak`=1 (negative acknowledge) and number N is checked for validity in the same way, and frees the packets through N. It then resends every still-stored packet after N, oldest first. Each resent packet carries `out_retry`=1, its original sequence number and its original payload.
- R6: A negative acknowledge that arrives during a replay restarts the replay from the newly reported point.
- R7: `in_ready` is 0 whenever a replay is in progress.
- R8: When packets are outstanding, no replay is running, and no valid event has been taken for `tmo_limit` cycles, the entire store is replayed from the oldest packet. A `tmo_limit` of 0 disables this.
- R9: An empty store never triggers a timeout replay.
- R10: A replay beat that is not taken (`out_ready`=0) holds its number and payload for as long as no event arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New packet offered |
| in_ready | output | 1 | New packet taken this cycle |
| in_data | input | DATA_W | New packet payload |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | DATA_W | Beat payload |
| out_seq | output | SEQ_W | Sequence number for the beat header |
| out_retry | output | 1 | 1 for a replayed beat |
| ev_valid | input | 1 | Acknowledge event strobe |
| ev_nak | input | 1 | 0 = acknowledge, 1 = negative acknowledge |
| ev_seq | input | SEQ_W | Sequence number carried by the event |
| tmo_limit | input | TMO_W | Timeout in cycles, 0 disables |

## Verification
The properties assume that an event's number refers to a packet the far end could actually have seen. In other words, it never lies more than half the number space away from the oldest outstanding packet. The bench keeps to this assumption by deriving every acknowledge and negative acknowledge from its own in-order receiver model, which always reports the last packet it accepted. The stall-hold property excludes cycles that carry an event, because an event is allowed to move the replay point. The long random run corrupts packets, drops acknowledges and negative acknowledges, and pushes enough packets through to wrap the sequence counter.

// File: rtl/lrb_pkg.sv
`timescale 1ns/1ps
package lrb_pkg;
   // encoding of the event kind input
   typedef enum logic {
      EV_ACK = 1'b0,
      EV_NAK = 1'b1
   } ev_kind_e;
endpackage

// File: rtl/lrb_store.sv
`timescale 1ns/1ps
// Replay storage: one entry per outstanding packet, indexed by low sequence bits.
module lrb_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) slot_q[wr_idx] <= wr_data;
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/lrb_seq_track.sv
`timescale 1ns/1ps
// Sequence bookkeeping: next number to issue, oldest outstanding, event decode.
module lrb_seq_track #(
   parameter int SEQ_W = 12,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_new,
   input  logic             ev_valid,
   input  logic [SEQ_W-1:0] ev_seq,
   output logic [SEQ_W-1:0] issue_q,
   output logic [SEQ_W-1:0] issue_nx,
   output logic [SEQ_W-1:0] oldest_q,
   output logic             full,
   output logic             busy,
   output logic             rel_ok,
   output logic [SEQ_W-1:0] rel_to,
   output logic [SEQ_W-1:0] rel_dist
);
   localparam logic [SEQ_W-1:0] CAP = SEQ_W'(DEPTH);

   logic [SEQ_W-1:0] inflight;

   assign inflight = issue_q - oldest_q;
   assign full     = (inflight == CAP);
   assign busy     = (inflight != '0);
   assign rel_to   = ev_seq + SEQ_W'(1);
   assign rel_dist = rel_to - oldest_q;
   assign rel_ok   = ev_valid && (rel_dist <= inflight);
   assign issue_nx = issue_q + SEQ_W'(take_new);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_q  <= '0;
         oldest_q <= '0;
      end else begin
         issue_q <= issue_nx;
         if (rel_ok) oldest_q <= rel_to;
      end
   end
endmodule

// File: rtl/lrb_replay_ctrl.sv
`timescale 1ns/1ps
// Go-back-N replay pointer and active flag.
module lrb_replay_ctrl #(
   parameter int SEQ_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_taken,
   input  logic             rel_ok,
   input  logic             is_nak,
   input  logic [SEQ_W-1:0] rel_to,
   input  logic [SEQ_W-1:0] rel_dist,
   input  logic [SEQ_W-1:0] oldest_q,
   input  logic [SEQ_W-1:0] issue_nx,
   input  logic             tmo_hit,
   output logic             active_q,
   output logic [SEQ_W-1:0] ptr_q
);
   logic             active_nx;
   logic [SEQ_W-1:0] ptr_nx;
   logic [SEQ_W-1:0] ptr_ofs;

   always_comb begin
      ptr_nx    = ptr_q;
      active_nx = active_q;
      if (active_q && beat_taken) ptr_nx = ptr_q + SEQ_W'(1);
      ptr_ofs = ptr_nx - oldest_q;
      if (rel_ok && is_nak) begin
         ptr_nx    = rel_to;
         active_nx = 1'b1;
      end else if (rel_ok && active_q && (ptr_ofs < rel_dist)) begin
         ptr_nx = rel_to;
      end else if (tmo_hit) begin
         ptr_nx    = oldest_q;
         active_nx = 1'b1;
      end
      if (ptr_nx == issue_nx) active_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ptr_q    <= '0;
      end else begin
         active_q <= active_nx;
         ptr_q    <= ptr_nx;
      end
   end
endmodule

// File: rtl/lrb_ack_timer.sv
`timescale 1ns/1ps
// Cycles since the last accepted event while packets wait for confirmation.
module lrb_ack_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             replaying,
   input  logic             rel_ok,
   input  logic [TMO_W-1:0] limit,
   output logic             hit
);
   logic [TMO_W-1:0] age_q;

   assign hit = (limit != '0) && busy && !replaying && !rel_ok && (age_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) age_q <= '0;
      else if (!busy || replaying || rel_ok || hit) age_q <= '0;
      else age_q <= age_q + TMO_W'(1);
   end
endmodule

// File: rtl/lrb_top.sv
`timescale 1ns/1ps
module lrb_top #(
   parameter int SEQ_W  = 12,
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [SEQ_W-1:0]  out_seq,
   output logic              out_retry,
   input  logic              ev_valid,
   input  logic              ev_nak,
   input  logic [SEQ_W-1:0]  ev_seq,
   input  logic [TMO_W-1:0]  tmo_limit
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DEPTH > (1 << (SEQ_W - 1))) begin : g_bad_window
      $error("DEPTH must not exceed half the sequence space");
   end
   if (TMO_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   logic             take_new, beat_taken, full, busy, rel_ok, tmo_hit, replaying, is_nak;
   logic [SEQ_W-1:0] issue_q, issue_nx, oldest_q, rel_to, rel_dist, ptr_q;
   logic [DATA_W-1:0] stored;

   assign is_nak     = (ev_nak == lrb_pkg::EV_NAK);
   assign in_ready   = out_ready && !replaying && !full;
   assign take_new   = in_valid && in_ready;
   assign out_valid  = replaying || (in_valid && !full);
   assign out_retry  = replaying;
   assign out_seq    = replaying ? ptr_q : issue_q;
   assign out_data   = replaying ? stored : in_data;
   assign beat_taken = out_valid && out_ready;

   lrb_seq_track #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_track (
      .clk(clk), .rst_n(rst_n), .take_new(take_new), .ev_valid(ev_valid), .ev_seq(ev_seq),
      .issue_q(issue_q), .issue_nx(issue_nx), .oldest_q(oldest_q), .full(full), .busy(busy),
      .rel_ok(rel_ok), .rel_to(rel_to), .rel_dist(rel_dist)
   );

   lrb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk(clk), .wr_en(take_new), .wr_idx(issue_q[IDX_W-1:0]), .wr_data(in_data),
      .rd_idx(ptr_q[IDX_W-1:0]), .rd_data(stored)
   );

   lrb_replay_ctrl #(.SEQ_W(SEQ_W)) u_replay (
      .clk(clk), .rst_n(rst_n), .beat_taken(beat_taken), .rel_ok(rel_ok), .is_nak(is_nak),
      .rel_to(rel_to), .rel_dist(rel_dist), .oldest_q(oldest_q), .issue_nx(issue_nx),
      .tmo_hit(tmo_hit), .active_q(replaying), .ptr_q(ptr_q)
   );

   lrb_ack_timer #(.TMO_W(TMO_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .busy(busy), .replaying(replaying), .rel_ok(rel_ok),
      .limit(tmo_limit), .hit(tmo_hit)
   );
endmodule

// File: rtl/lrb_chk.sv
`timescale 1ns/1ps
module lrb_chk #(
   parameter int SEQ_W  = 12,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic [SEQ_W-1:0]  out_seq,
   input logic              out_retry,
   input logic              ev_valid
);
   logic             fresh_fire, seen_q;
   logic [SEQ_W-1:0] last_q;

   assign fresh_fire = out_valid && out_ready && !out_retry;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else if (fresh_fire) begin
         seen_q <= 1'b1;
         last_q <= out_seq;
      end
   end

   // R7
   retry_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_retry |-> !in_ready);

   // R2
   accept_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (out_valid && out_ready && !out_retry && out_data == in_data));

   // R1
   fresh_seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh_fire && seen_q) |-> (out_seq == last_q + SEQ_W'(1)));

   // R10
   retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_retry && !out_ready && !ev_valid) |=> (out_retry && $stable(out_seq) && $stable(out_data)));
endmodule

bind lrb_top lrb_chk #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_lrb_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_seq(out_seq),
   .out_retry(out_retry), .ev_valid(ev_valid)
);

// File: tb/test_lrb_top.sv
`timescale 1ns/1ps
module test_lrb_top;
   localparam int SW = 12, DW = 16, DEPTH = 8, TW = 16, NPKT = 5000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_ready;
   logic [DW-1:0] in_data = '0;
   logic out_valid, out_ready = 1'b0, out_retry;
   logic [DW-1:0] out_data;
   logic [SW-1:0] out_seq;
   logic ev_valid = 1'b0, ev_nak = 1'b0;
   logic [SW-1:0] ev_seq = '0;
   logic [TW-1:0] tmo_limit = '0;

   int total = 0, bad = 0;
   logic s_vld, s_fire, s_rty, s_rdy;
   logic [SW-1:0] s_seq;
   logic [DW-1:0] s_data;

   always #4 clk = ~clk;

   lrb_top i_lrb_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_seq(out_seq),
      .out_retry(out_retry), .ev_valid(ev_valid), .ev_nak(ev_nak), .ev_seq(ev_seq),
      .tmo_limit(tmo_limit)
   );

   function automatic logic [DW-1:0] pay(int s);
      logic [SW-1:0] q = SW'(s);
      return {q[3:0] ^ 4'h9, q};
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // sample just before the rising edge, then move to the next falling edge
   task automatic tick();
      #3;
      s_vld  = out_valid;
      s_fire = out_valid && out_ready;
      s_rty  = out_retry;
      s_rdy  = in_ready;
      s_seq  = out_seq;
      s_data = out_data;
      @(negedge clk);
   endtask

   task automatic send_ev(bit nak, int n);
      ev_valid = 1'b1; ev_nak = nak; ev_seq = SW'(n);
      tick();
      ev_valid = 1'b0;
   endtask

   task automatic want(string req, int seq, bit rty, int data);
      tick();
      chk(s_fire && s_seq == SW'(seq) && s_rty == rty && s_data == DW'(data), req, int'(s_seq), seq);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; ev_valid = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 190000);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int w, fires, fresh, rx_exp, mbase, ev_to, off;
      bit pend, sent;
      logic [31:0] rs;
      @(negedge clk);
      out_ready = 1'b1;
      do_reset();

      // reset state
      tick();
      chk(!s_vld, "R2 reset out_valid", int'(s_vld), 0);
      chk(s_rdy, "R2 reset in_ready", int'(s_rdy), 1);

      // R1/R2: fill the store with fresh packets
      for (int i = 0; i < DEPTH; i++) begin
         in_valid = 1'b1; in_data = DW'(16'hA000 + i);
         want("R1", i, 1'b0, 16'hA000 + i);
         chk(s_rdy, "R2 accept", int'(s_rdy), 1);
      end
      // R3: full store stalls
      in_data = 16'hA008;
      tick();
      chk(!s_rdy && !s_vld, "R3 full stall", int'(s_rdy), 0);

      // R4: acknowledge for a number not outstanding is ignored
      in_valid = 1'b0;
      send_ev(1'b0, 100);
      in_valid = 1'b1;
      tick();
      chk(!s_rdy, "R4 ignored ack", int'(s_rdy), 0);
      in_valid = 1'b0;
      send_ev(1'b0, 2);
      tick();
      chk(s_rdy, "R4 ack frees", int'(s_rdy), 1);

      // R5/R7: negative acknowledge of 4 replays 5..7
      send_ev(1'b1, 4);
      for (int i = 5; i < 8; i++) begin
         want("R5", i, 1'b1, 16'hA000 + i);
         chk(!s_rdy, "R7 blocked", int'(s_rdy), 0);
      end
      tick();
      chk(!s_vld && s_rdy, "R7 released", int'(s_rdy), 1);

      // R10/R6: hold while stalled, then restart from a new report
      send_ev(1'b1, 4);
      want("R6", 5, 1'b1, 16'hA005);
      out_ready = 1'b0;
      tick();
      chk(s_vld && s_rty && s_seq == 12'd6, "R10 hold a", int'(s_seq), 6);
      tick();
      chk(s_vld && s_rty && s_seq == 12'd6 && s_data == 16'hA006, "R10 hold b", int'(s_seq), 6);
      send_ev(1'b1, 4);
      out_ready = 1'b1;
      for (int i = 5; i < 8; i++) want("R6 restart", i, 1'b1, 16'hA000 + i);
      tick();
      chk(!s_vld, "R6 end", int'(s_vld), 0);

      // R8: timeout replays the whole store
      tmo_limit = TW'(20);
      send_ev(1'b1, 4);
      for (int i = 5; i < 8; i++) want("R8 setup", i, 1'b1, 16'hA000 + i);
      w = 0;
      for (int k = 0; k < 40; k++) begin
         tick(); w++;
         if (s_fire) break;
      end
      chk(s_fire && s_rty && s_seq == 12'd5 && w >= 19 && w <= 23, "R8 timeout", w, 21);
      want("R8", 6, 1'b1, 16'hA006);
      want("R8", 7, 1'b1, 16'hA007);

      // R9: empty store stays quiet
      tick();
      send_ev(1'b0, 7);
      fires = 0;
      for (int k = 0; k < 60; k++) begin tick(); if (s_fire) fires++; end
      chk(fires == 0, "R9 empty", fires, 0);

      // R8: limit 0 disables the timeout
      tmo_limit = '0;
      in_valid = 1'b1; in_data = 16'hB008;
      want("R1 after ack", 8, 1'b0, 16'hB008);
      in_valid = 1'b0;
      fires = 0;
      for (int k = 0; k < 60; k++) begin tick(); if (s_fire) fires++; end
      chk(fires == 0, "R8 disabled", fires, 0);

      // random run: corruption, dropped events, sequence wrap
      do_reset();
      tmo_limit = TW'(50);
      rs = 32'h1234_5678;
      fresh = 0; rx_exp = 0; mbase = 0; pend = 1'b0;
      for (int step = 0; step < 150000 && rx_exp < NPKT; step++) begin
         rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
         in_valid  = (fresh < NPKT) && (rs[1:0] != 2'b00);
         in_data   = pay(fresh);
         out_ready = (rs[4:2] != 3'b000);
         ev_valid  = 1'b0;
         sent = 1'b0;
         ev_to = rx_exp;
         if (pend) begin
            pend = 1'b0;
            if (rs[9:7] != 3'b000) begin
               ev_valid = 1'b1; ev_nak = 1'b1; ev_seq = SW'(rx_exp - 1); sent = 1'b1;
            end
         end else if (rs[14:12] == 3'b000 && rs[15]) begin
            ev_valid = 1'b1; ev_nak = 1'b0; ev_seq = SW'(rx_exp - 1); sent = 1'b1;
         end
         tick();
         if (s_fire) begin
            if (!s_rty) begin
               chk(s_seq == SW'(fresh) && s_data == pay(fresh), "R1 fresh", int'(s_seq), fresh % 4096);
               chk((fresh - mbase) < DEPTH, "R3 window", fresh - mbase, DEPTH - 1);
               fresh++;
            end else begin
               off = (int'(s_seq) - mbase) & 4095;
               chk(s_data == pay(int'(s_seq)) && off < (fresh - mbase), "R5 replay", off, fresh - mbase);
               chk(!s_rdy, "R7 replay", int'(s_rdy), 0);
            end
            if (s_seq == SW'(rx_exp)) begin
               if (rs[20:16] == 5'd0 && !pend) pend = 1'b1;
               else rx_exp++;
            end
         end
         if (sent) mbase = ev_to;
      end
      ev_valid = 1'b0; in_valid = 1'b0;
      chk(rx_exp == NPKT && fresh == NPKT, "R5 delivery", rx_exp, NPKT);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule